// File: doc/BRIEF.md
# Embedded Split-Transaction Microframe Scheduler

This block sits inside a high-speed USB host controller that contains its own transaction translator. It chooses which stored full- or low-speed transaction goes out on the downstream bus, and when. There are two queues. The periodic queue holds entries that each carry the host-side microframe number they belong to. The asynchronous queue holds entries that each carry an estimate of how long they will occupy the bus, in bit-times. Periodic work starts at the frame marker. An entry tagged for host microframe N may go out in bus microframe N, with no pipeline offset. Asynchronous entries only fill the time that is left once the periodic queue has drained.

One transaction is in flight at a time. A valid/ready offer carries it to the downstream engine. The block then waits for a completion pulse and turns it into a split handshake report, which is built from the stored in-flight state rather than from any high-speed bus traffic. Entries that declare a maximum packet size above 1023 bytes are consumed at enqueue, never stored, and flagged. At every frame marker, periodic entries left over from the previous frame are discarded and a missed-frame flag is raised.

Top module: `tt_uframe_sched`

## Requirements
- R1: After reset, `iss_valid`, `hs_valid`, `enq_rej` and `frame_missed` are 0, `bus_uframe` is 0 and both enqueue ports are ready. No transaction is offered until the first `sof` pulse, even when entries are stored.
- R2: `bus_uframe` becomes 0 on `sof` and increases by one on each `uf_tick`, saturating at 7. A periodic entry with tag N is offered only while `bus_uframe` >= N.
- R3: Each queue holds 8 entries and issues them in arrival order. When a queue holds 8 entries its ready output is 0 and the offered entry is not taken.
- R4: An asynchronous entry is offered only when the periodic queue is empty and nothing is in flight.
- R5: An asynchronous entry is offered only when its duration is less than or equal to `time_left`. Otherwise it waits; equality is allowed.
- R6: A rising `iss_valid` stays high with a stable `iss_id` until `iss_ready`. No new offer is made until `cmp_valid` arrives. A `cmp_valid` pulse while no transaction awaits completion is ignored.
- R7: One cycle after `cmp_valid` is accepted, `hs_valid` pulses for one cycle with the in-flight `hs_id` and `hs_periodic`, and with `hs_status` equal to `cmp_status` (0 = ACK, 1 = NAK, 2 = error).
- R8: An entry with `*_mps` > 1023 is consumed but not stored. In the next cycle `enq_rej` bit 0 (periodic) or bit 1 (asynchronous) pulses.
- R9: On `sof` every stored periodic entry is discarded, and `frame_missed` is set to 1 if any was discarded, otherwise to 0; it holds until the next `sof`. A periodic entry pushed in the `sof` cycle is kept. No offer starts in the `sof` cycle.
- R10: Synchronous active-high `rst` empties both queues and returns the block to waiting for `sof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Frame start pulse |
| uf_tick | input | 1 | Microframe boundary pulse |
| time_left | input | DUR_W | Bit-times remaining before next frame start |
| per_valid | input | 1 | Periodic enqueue request |
| per_ready | output | 1 | Periodic queue can accept |
| per_id | input | ID_W | Periodic transaction handle |
| per_tag | input | TAG_W | Host microframe number |
| per_mps | input | MPS_W | Periodic maximum packet size |
| asy_valid | input | 1 | Asynchronous enqueue request |
| asy_ready | output | 1 | Asynchronous queue can accept |
| asy_id | input | ID_W | Asynchronous transaction handle |
| asy_dur | input | DUR_W | Duration estimate in bit-times |
| asy_mps | input | MPS_W | Asynchronous maximum packet size |
| iss_valid | output | 1 | Transaction offered to bus engine |
| iss_ready | input | 1 | Bus engine accepts the offer |
| iss_id | output | ID_W | Handle of offered transaction |
| iss_periodic | output | 1 | Offered transaction is periodic |
| cmp_valid | input | 1 | Completion pulse |
| cmp_status | input | 2 | Completion result code |
| hs_valid | output | 1 | Split handshake report pulse |
| hs_id | output | ID_W | Handle of completed transaction |
| hs_periodic | output | 1 | Completed transaction was periodic |
| hs_status | output | 2 | Reported result code |
| enq_rej | output | 2 | Oversize rejection pulses |
| frame_missed | output | 1 | Periodic work was dropped at last frame start |
| bus_uframe | output | TAG_W | Current bus microframe |

## Verification
The delicate overlap is a frame marker that arrives in the same cycle as a periodic push. That one edge has to discard the older stored entries, keep the new one, set the missed flag from the old contents and hold back any offer. The bench provokes it by filling the queue with entries tagged for microframe 7 and then raising `sof` together with a push tagged 0. It then expects the new entry to go out first and the flag to read 1. Advancing to microframe 7 afterwards must produce no further offer. A second overlap is a completion pulse that arrives while an offer is still waiting for `iss_ready`. The bench judges it by checking that no report appears and the offer stays up.

// File: rtl/tt_sched_pkg.sv
package tt_sched_pkg;
  localparam int unsigned ID_W_DEF  = 8;
  localparam int unsigned TAG_W_DEF = 3;
  localparam int unsigned DUR_W_DEF = 14;
  localparam int unsigned MPS_W_DEF = 11;
  localparam int unsigned MPS_LIMIT = 1023;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_OFFER = 2'd1,
    S_WAIT  = 2'd2
  } sched_state_e;
endpackage

// File: rtl/tt_sched_fifo.sv
module tt_sched_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q <= wr_q + AW'(push);
      if (flush) begin
        rd_q  <= wr_q;
        cnt_q <= CW'(push);
      end else begin
        rd_q  <= rd_q + AW'(pop);
        cnt_q <= cnt_q + CW'(push) - CW'(pop);
      end
    end
  end

  assign dout  = mem[rd_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/tt_sched_pick.sv
module tt_sched_pick #(
  parameter int unsigned TAG_W = 3,
  parameter int unsigned DUR_W = 14
) (
  input  logic             started,
  input  logic             idle,
  input  logic             sof,
  input  logic             per_empty,
  input  logic [TAG_W-1:0] per_tag_h,
  input  logic [TAG_W-1:0] uframe,
  input  logic             asy_empty,
  input  logic [DUR_W-1:0] asy_dur_h,
  input  logic [DUR_W-1:0] time_left,
  output logic             take_per,
  output logic             take_asy
);
  logic may_start;

  always_comb begin
    may_start = started && idle && !sof;
    take_per  = may_start && !per_empty && (per_tag_h <= uframe);
    take_asy  = may_start && per_empty && !asy_empty && (asy_dur_h <= time_left);
  end
endmodule

// File: rtl/tt_uframe_sched.sv
module tt_uframe_sched
  import tt_sched_pkg::*;
#(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned ID_W    = ID_W_DEF,
  parameter int unsigned TAG_W   = TAG_W_DEF,
  parameter int unsigned DUR_W   = DUR_W_DEF,
  parameter int unsigned MPS_W   = MPS_W_DEF,
  parameter int unsigned MPS_MAX = MPS_LIMIT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sof,
  input  logic             uf_tick,
  input  logic [DUR_W-1:0] time_left,
  input  logic             per_valid,
  output logic             per_ready,
  input  logic [ID_W-1:0]  per_id,
  input  logic [TAG_W-1:0] per_tag,
  input  logic [MPS_W-1:0] per_mps,
  input  logic             asy_valid,
  output logic             asy_ready,
  input  logic [ID_W-1:0]  asy_id,
  input  logic [DUR_W-1:0] asy_dur,
  input  logic [MPS_W-1:0] asy_mps,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic [ID_W-1:0]  iss_id,
  output logic             iss_periodic,
  input  logic             cmp_valid,
  input  logic [1:0]       cmp_status,
  output logic             hs_valid,
  output logic [ID_W-1:0]  hs_id,
  output logic             hs_periodic,
  output logic [1:0]       hs_status,
  output logic [1:0]       enq_rej,
  output logic             frame_missed,
  output logic [TAG_W-1:0] bus_uframe
);
  localparam int unsigned PW = ID_W + TAG_W;
  localparam int unsigned AW = ID_W + DUR_W;
  localparam int unsigned CW = $clog2(DEPTH) + 1;

  sched_state_e state_q;
  logic         started_q;
  logic [TAG_W-1:0] uf_q;

  logic per_bad, asy_bad, per_push, asy_push;
  logic take_per, take_asy;
  logic [PW-1:0] per_dout;
  logic [AW-1:0] asy_dout;
  logic [CW-1:0] per_cnt, asy_cnt;
  logic per_full, per_empty, asy_full, asy_empty;
  logic [TAG_W-1:0] per_tag_h;
  logic [ID_W-1:0]  per_id_h, asy_id_h;
  logic [DUR_W-1:0] asy_dur_h;

  assign per_ready = !per_full;
  assign asy_ready = !asy_full;
  assign per_bad   = per_valid && per_ready && (per_mps > MPS_W'(MPS_MAX));
  assign asy_bad   = asy_valid && asy_ready && (asy_mps > MPS_W'(MPS_MAX));
  assign per_push  = per_valid && per_ready && !per_bad;
  assign asy_push  = asy_valid && asy_ready && !asy_bad;

  tt_sched_fifo #(.W(PW), .DEPTH(DEPTH)) u_per_q (
    .clk(clk), .rst(rst), .flush(sof),
    .push(per_push), .din({per_id, per_tag}), .pop(take_per),
    .dout(per_dout), .count(per_cnt), .full(per_full), .empty(per_empty)
  );

  tt_sched_fifo #(.W(AW), .DEPTH(DEPTH)) u_asy_q (
    .clk(clk), .rst(rst), .flush(1'b0),
    .push(asy_push), .din({asy_id, asy_dur}), .pop(take_asy),
    .dout(asy_dout), .count(asy_cnt), .full(asy_full), .empty(asy_empty)
  );

  assign per_tag_h = per_dout[TAG_W-1:0];
  assign per_id_h  = per_dout[PW-1:TAG_W];
  assign asy_dur_h = asy_dout[DUR_W-1:0];
  assign asy_id_h  = asy_dout[AW-1:DUR_W];

  tt_sched_pick #(.TAG_W(TAG_W), .DUR_W(DUR_W)) u_pick (
    .started(started_q), .idle(state_q == S_IDLE), .sof(sof),
    .per_empty(per_empty), .per_tag_h(per_tag_h), .uframe(uf_q),
    .asy_empty(asy_empty), .asy_dur_h(asy_dur_h), .time_left(time_left),
    .take_per(take_per), .take_asy(take_asy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_IDLE;
      started_q    <= 1'b0;
      uf_q         <= '0;
      iss_valid    <= 1'b0;
      iss_id       <= '0;
      iss_periodic <= 1'b0;
      hs_valid     <= 1'b0;
      hs_id        <= '0;
      hs_periodic  <= 1'b0;
      hs_status    <= '0;
      enq_rej      <= '0;
      frame_missed <= 1'b0;
    end else begin
      enq_rej  <= {asy_bad, per_bad};
      hs_valid <= 1'b0;
      if (sof) begin
        started_q    <= 1'b1;
        uf_q         <= '0;
        frame_missed <= !per_empty;
      end else if (uf_tick && (uf_q != {TAG_W{1'b1}})) begin
        uf_q <= uf_q + 1'b1;
      end
      unique case (state_q)
        S_IDLE: if (take_per || take_asy) begin
          state_q      <= S_OFFER;
          iss_valid    <= 1'b1;
          iss_id       <= take_per ? per_id_h : asy_id_h;
          iss_periodic <= take_per;
        end
        S_OFFER: if (iss_ready) begin
          state_q   <= S_WAIT;
          iss_valid <= 1'b0;
        end
        S_WAIT: if (cmp_valid) begin
          state_q     <= S_IDLE;
          hs_valid    <= 1'b1;
          hs_id       <= iss_id;
          hs_periodic <= iss_periodic;
          hs_status   <= cmp_status;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign bus_uframe = uf_q;
endmodule

// File: rtl/tt_uframe_sched_chk.sv
module tt_uframe_sched_chk #(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned ID_W    = 8,
  parameter int unsigned TAG_W   = 3,
  parameter int unsigned DUR_W   = 14,
  parameter int unsigned MPS_W   = 11,
  parameter int unsigned MPS_MAX = 1023,
  localparam int unsigned CW     = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             started,
  input logic             sof,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [ID_W-1:0]  iss_id,
  input logic             iss_periodic,
  input logic             cmp_valid,
  input logic             hs_valid,
  input logic             per_valid,
  input logic             per_ready,
  input logic [MPS_W-1:0] per_mps,
  input logic [1:0]       enq_rej,
  input logic [TAG_W-1:0] bus_uframe,
  input logic [CW-1:0]    per_cnt,
  input logic [CW-1:0]    asy_cnt,
  input logic [TAG_W-1:0] per_tag_h,
  input logic [DUR_W-1:0] asy_dur_h,
  input logic [DUR_W-1:0] time_left
);
  p_wait_sof_r1: assert property (@(posedge clk) disable iff (rst)
    !started |-> !iss_valid);

  p_tag_due_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(iss_valid) && iss_periodic |-> $past(per_tag_h) <= $past(bus_uframe));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (per_cnt <= CW'(DEPTH)) && (asy_cnt <= CW'(DEPTH)));

  p_async_last_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(iss_valid) && !iss_periodic |-> $past(per_cnt) == '0);

  p_async_fits_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(iss_valid) && !iss_periodic |-> $past(asy_dur_h) <= $past(time_left));

  p_offer_hold_r6: assert property (@(posedge clk) disable iff (rst)
    iss_valid && !iss_ready |=> iss_valid && $stable(iss_id));

  p_report_cause_r7: assert property (@(posedge clk) disable iff (rst)
    hs_valid |-> $past(cmp_valid));

  p_oversize_r8: assert property (@(posedge clk) disable iff (rst)
    per_valid && per_ready && (per_mps > MPS_W'(MPS_MAX)) |=> enq_rej[0]);

  p_uframe_zero_r9: assert property (@(posedge clk) disable iff (rst)
    sof |=> bus_uframe == '0);

  p_no_start_at_sof_r9: assert property (@(posedge clk) disable iff (rst)
    sof && !iss_valid |=> !iss_valid);
endmodule

bind tt_uframe_sched tt_uframe_sched_chk #(
  .DEPTH(DEPTH), .ID_W(ID_W), .TAG_W(TAG_W), .DUR_W(DUR_W),
  .MPS_W(MPS_W), .MPS_MAX(MPS_MAX)
) u_chk (
  .clk(clk), .rst(rst), .started(started_q), .sof(sof),
  .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_id(iss_id),
  .iss_periodic(iss_periodic), .cmp_valid(cmp_valid), .hs_valid(hs_valid),
  .per_valid(per_valid), .per_ready(per_ready), .per_mps(per_mps),
  .enq_rej(enq_rej), .bus_uframe(bus_uframe), .per_cnt(per_cnt),
  .asy_cnt(asy_cnt), .per_tag_h(per_tag_h), .asy_dur_h(asy_dur_h),
  .time_left(time_left)
);

// File: tb/tt_uframe_sched_tb_top.sv
`timescale 1ns/1ps
module tt_uframe_sched_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sof = 0, uf_tick = 0;
  logic [13:0] time_left = 0;
  logic per_valid = 0, per_ready;
  logic [7:0] per_id = 0;
  logic [2:0] per_tag = 0;
  logic [10:0] per_mps = 0;
  logic asy_valid = 0, asy_ready;
  logic [7:0] asy_id = 0;
  logic [13:0] asy_dur = 0;
  logic [10:0] asy_mps = 0;
  logic iss_valid, iss_ready = 0, iss_periodic;
  logic [7:0] iss_id;
  logic cmp_valid = 0;
  logic [1:0] cmp_status = 0;
  logic hs_valid, hs_periodic;
  logic [7:0] hs_id;
  logic [1:0] hs_status, enq_rej;
  logic frame_missed;
  logic [2:0] bus_uframe;

  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  tt_uframe_sched dut_i (
    .clk(clk), .rst(rst), .sof(sof), .uf_tick(uf_tick), .time_left(time_left),
    .per_valid(per_valid), .per_ready(per_ready), .per_id(per_id),
    .per_tag(per_tag), .per_mps(per_mps),
    .asy_valid(asy_valid), .asy_ready(asy_ready), .asy_id(asy_id),
    .asy_dur(asy_dur), .asy_mps(asy_mps),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_id(iss_id),
    .iss_periodic(iss_periodic), .cmp_valid(cmp_valid), .cmp_status(cmp_status),
    .hs_valid(hs_valid), .hs_id(hs_id), .hs_periodic(hs_periodic),
    .hs_status(hs_status), .enq_rej(enq_rej), .frame_missed(frame_missed),
    .bus_uframe(bus_uframe)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  function automatic bit fits(input int dur, input int left);
    return dur <= left;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic enq_per(input int id, input int tag, input int mps);
    per_valid = 1; per_id = 8'(id); per_tag = 3'(tag); per_mps = 11'(mps);
    step();
    per_valid = 0;
  endtask

  task automatic enq_asy(input int id, input int dur, input int mps);
    asy_valid = 1; asy_id = 8'(id); asy_dur = 14'(dur); asy_mps = 11'(mps);
    step();
    asy_valid = 0;
  endtask

  task automatic pulse_sof();
    sof = 1; step(); sof = 0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      uf_tick = 1; step(); uf_tick = 0;
    end
  endtask

  task automatic wait_issue(input int id, input bit per, input string req);
    for (int i = 0; i < 30 && !iss_valid; i++) step();
    chk(iss_valid === 1'b1, req, int'(iss_valid), 1);
    chk(iss_id == 8'(id), req, int'(iss_id), id);
    chk(iss_periodic == per, req, int'(iss_periodic), int'(per));
  endtask

  task automatic finish_txn(input int hold, input int st, input int id, input bit per);
    for (int h = 0; h < hold; h++) begin
      iss_ready = 0;
      cmp_valid = (h == 0);
      step();
      cmp_valid = 0;
      chk(iss_valid === 1'b1, "R6 offer held", int'(iss_valid), 1);
      chk(hs_valid === 1'b0, "R6 early completion ignored", int'(hs_valid), 0);
    end
    iss_ready = 1; step(); iss_ready = 0;
    chk(iss_valid === 1'b0, "R6 offer dropped after ready", int'(iss_valid), 0);
    step();
    chk(iss_valid === 1'b0, "R6 no offer while in flight", int'(iss_valid), 0);
    cmp_valid = 1; cmp_status = 2'(st); step(); cmp_valid = 0;
    chk(hs_valid === 1'b1, "R7 report pulse", int'(hs_valid), 1);
    chk(hs_id == 8'(id), "R7 report id", int'(hs_id), id);
    chk(hs_periodic == per, "R7 report kind", int'(hs_periodic), int'(per));
    chk(hs_status == 2'(st), "R7 report status", int'(hs_status), st);
    step();
    chk(hs_valid === 1'b0, "R7 single pulse", int'(hs_valid), 0);
  endtask

  // random phase model
  logic [7:0] mq_id[$];
  int mq_dur[$];

  initial begin
    int ph, hold, dly, tl_applied, last_id, last_st, nid;
    bit exp_rej, drv_acc;
    void'($urandom(32'd1357));
    steps(3);
    rst = 0;
    step();
    // R1 reset state
    chk(iss_valid === 1'b0, "R1 iss_valid", int'(iss_valid), 0);
    chk(hs_valid === 1'b0, "R1 hs_valid", int'(hs_valid), 0);
    chk(per_ready && asy_ready, "R1 ready", int'({per_ready, asy_ready}), 3);
    chk(frame_missed === 1'b0 && enq_rej == 0, "R1 flags", int'({frame_missed, enq_rej}), 0);
    chk(bus_uframe == 0, "R1 uframe", int'(bus_uframe), 0);
    time_left = 14'd1000;
    enq_per(1, 0, 64);
    enq_asy(2, 1, 64);
    steps(5);
    chk(iss_valid === 1'b0, "R1 nothing before first sof", int'(iss_valid), 0);
    // R9 stale periodic dropped, async survives
    pulse_sof();
    chk(frame_missed === 1'b1, "R9 missed flag set", int'(frame_missed), 1);
    wait_issue(2, 0, "R9 async kept, periodic flushed");
    finish_txn(0, 0, 2, 0);
    // R2 tag gating
    enq_per(3, 0, 100);
    enq_per(4, 1, 100);
    wait_issue(3, 1, "R2 tag 0 in uframe 0");
    finish_txn(3, 1, 3, 1);
    steps(5);
    chk(iss_valid === 1'b0, "R2 tag 1 held in uframe 0", int'(iss_valid), 0);
    tick(1);
    chk(bus_uframe == 1, "R2 uframe count", int'(bus_uframe), 1);
    wait_issue(4, 1, "R2 tag 1 in uframe 1");
    finish_txn(1, 2, 4, 1);
    // R5 duration fit, equality allowed
    time_left = 14'd99;
    enq_asy(5, 100, 10);
    steps(6);
    chk(iss_valid === 1'b0, "R5 too long waits", int'(iss_valid), 0);
    time_left = 14'd100;
    wait_issue(5, 0, "R5 equal fits");
    finish_txn(0, 0, 5, 0);
    // R4 periodic before async
    time_left = 14'd1000;
    enq_per(6, 7, 10);
    enq_asy(7, 1, 10);
    steps(6);
    chk(iss_valid === 1'b0, "R4 async blocked by pending periodic", int'(iss_valid), 0);
    tick(6);
    wait_issue(6, 1, "R4 periodic first");
    finish_txn(0, 0, 6, 1);
    wait_issue(7, 0, "R4 async after periodic drained");
    finish_txn(0, 0, 7, 0);
    tick(1);
    chk(bus_uframe == 7, "R2 uframe saturates", int'(bus_uframe), 7);
    // R8 oversize
    enq_per(8, 0, 1024);
    chk(enq_rej == 2'b01, "R8 periodic reject", int'(enq_rej), 1);
    steps(3);
    chk(iss_valid === 1'b0, "R8 rejected not stored", int'(iss_valid), 0);
    enq_per(9, 0, 1023);
    chk(enq_rej == 2'b00, "R8 1023 accepted", int'(enq_rej), 0);
    wait_issue(9, 1, "R8 accepted entry issues");
    finish_txn(0, 0, 9, 1);
    enq_asy(10, 1, 2047);
    chk(enq_rej == 2'b10, "R8 async reject", int'(enq_rej), 2);
    steps(3);
    chk(iss_valid === 1'b0, "R8 async rejected not stored", int'(iss_valid), 0);
    // R3 order
    enq_per(11, 0, 8);
    enq_per(12, 0, 8);
    enq_per(13, 0, 8);
    wait_issue(11, 1, "R3 order first");
    finish_txn(0, 0, 11, 1);
    wait_issue(12, 1, "R3 order second");
    finish_txn(0, 0, 12, 1);
    wait_issue(13, 1, "R3 order third");
    finish_txn(0, 0, 13, 1);
    // R9 empty at sof clears flag
    pulse_sof();
    chk(frame_missed === 1'b0, "R9 nothing dropped", int'(frame_missed), 0);
    // R3 full
    for (int i = 0; i < 8; i++) enq_per(20 + i, 7, 8);
    chk(per_ready === 1'b0, "R3 full not ready", int'(per_ready), 0);
    enq_per(28, 7, 8);
    chk(per_ready === 1'b0, "R3 still full", int'(per_ready), 0);
    pulse_sof();
    chk(frame_missed === 1'b1 && per_ready === 1'b1, "R9 full queue flushed",
        int'({frame_missed, per_ready}), 3);
    // R9 push in the sof cycle survives
    for (int i = 0; i < 3; i++) enq_per(30 + i, 7, 8);
    sof = 1; per_valid = 1; per_id = 8'd33; per_tag = 3'd0; per_mps = 11'd8;
    step();
    sof = 0; per_valid = 0;
    chk(frame_missed === 1'b1, "R9 flag with same-cycle push", int'(frame_missed), 1);
    chk(iss_valid === 1'b0, "R9 no start in sof cycle", int'(iss_valid), 0);
    wait_issue(33, 1, "R9 same-cycle push kept");
    finish_txn(0, 0, 33, 1);
    tick(7);
    steps(3);
    chk(iss_valid === 1'b0, "R9 flushed entries gone", int'(iss_valid), 0);
    pulse_sof();
    chk(frame_missed === 1'b0, "R9 flag cleared", int'(frame_missed), 0);
    // R10 reset mid-run
    time_left = 14'd0;
    enq_asy(41, 5000, 8);
    enq_per(42, 7, 8);
    rst = 1; steps(2); rst = 0;
    chk(iss_valid === 1'b0 && frame_missed === 1'b0, "R10 outputs cleared",
        int'({iss_valid, frame_missed}), 0);
    chk(per_ready && asy_ready && bus_uframe == 0, "R10 ready and uframe",
        int'({per_ready, asy_ready}), 3);
    time_left = 14'd8000;
    steps(5);
    chk(iss_valid === 1'b0, "R10 waits for sof", int'(iss_valid), 0);
    pulse_sof();
    chk(frame_missed === 1'b0, "R10 periodic queue emptied", int'(frame_missed), 0);
    steps(5);
    chk(iss_valid === 1'b0, "R10 async queue emptied", int'(iss_valid), 0);

    // random asynchronous traffic (R3, R5, R6, R7, R8)
    ph = 0; hold = 0; dly = 0; tl_applied = 0; last_id = 0; last_st = 0;
    nid = 100; exp_rej = 0;
    for (int k = 0; k < 4000; k++) begin
      if (exp_rej) chk(enq_rej[1] === 1'b1, "R8 random reject", int'(enq_rej), 2);
      case (ph)
        0: if (iss_valid) begin
             chk(mq_id.size() > 0 && iss_id == mq_id[0], "R3 random order",
                 int'(iss_id), mq_id.size() > 0 ? int'(mq_id[0]) : -1);
             chk(mq_dur.size() > 0 && fits(mq_dur[0], tl_applied), "R5 random fit",
                 mq_dur.size() > 0 ? mq_dur[0] : -1, tl_applied);
             last_id = int'(iss_id);
             if (mq_id.size() > 0) begin void'(mq_id.pop_front()); void'(mq_dur.pop_front()); end
             hold = int'($urandom % 3);
             ph = 1;
           end
        1: chk(iss_valid === 1'b1, "R6 random hold", int'(iss_valid), 1);
        2: chk(iss_valid === 1'b0, "R6 random in flight", int'(iss_valid), 0);
        default: begin
          chk(hs_valid === 1'b1 && hs_id == 8'(last_id), "R7 random report",
              int'(hs_id), last_id);
          chk(hs_status == 2'(last_st), "R7 random status", int'(hs_status), last_st);
          ph = 0;
        end
      endcase
      // drive
      cmp_valid = 0; iss_ready = 0;
      if (ph == 1) begin
        if (hold > 0) hold--;
        else begin iss_ready = 1; ph = 2; dly = int'($urandom % 3); end
      end else if (ph == 2) begin
        if (dly > 0) dly--;
        else begin
          cmp_valid = 1; last_st = int'($urandom % 3);
          cmp_status = 2'(last_st); ph = 3;
        end
      end
      time_left = 14'($urandom % 600);
      tl_applied = int'(time_left);
      asy_valid = ($urandom % 3 == 0);
      asy_id = 8'(nid);
      asy_dur = 14'($urandom % 500);
      asy_mps = ($urandom % 8 == 0) ? 11'(1024 + $urandom % 1024) : 11'($urandom % 1024);
      drv_acc = asy_valid && asy_ready;
      exp_rej = drv_acc && (asy_mps > 11'd1023);
      if (drv_acc && !exp_rej) begin
        mq_id.push_back(8'(nid));
        mq_dur.push_back(int'(asy_dur));
      end
      if (asy_valid && asy_ready) nid = (nid == 255) ? 100 : nid + 1;
      step();
    end
    asy_valid = 0; cmp_valid = 0; iss_ready = 0;
    step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule